// File: doc/BRIEF.md
# Two-Bank Byte Register File with Alias Window

This block is the data memory of a small 8-bit processor core. Each access carries a 7-bit offset from the instruction, a status byte and an 8-bit pointer. A direct access puts the status bank bit above the offset to form an 8-bit address. An indirect access, selected by offset 00h, takes the pointer as the whole 8-bit address. The address is then decoded into one of four classes: a forwarded special-function register, a general-purpose RAM byte, an unimplemented hole, or the null indirect location.

General-purpose storage does not form one contiguous range. Bank 0 holds a large window. Bank 1 holds a smaller window of its own and a high window that aliases onto the top of the bank-0 window. The same storage byte backs both addresses of an alias pair, so a write through either address shows at both. Special-function register accesses pass to an external port. Reads are combinational and writes commit on the rising clock edge.

Top module: `banked_regfile`

## Requirements
- R1: For a direct access (offset not 00h) the full address is {status[5], offset[6:0]}. Status bits 7:6 and 4:0 have no effect on the address.
- R2: Addresses whose low 7 bits lie in 01h–1Fh select the special-function port. In that case sfr_sel_o=1, sfr_addr_o carries the full address and rd_data_o equals sfr_rdata_i. A write raises sfr_we_o with sfr_wdata_o=wr_data_i.
- R3: Addresses 20h–7Fh are general-purpose RAM. A byte written with wr_en_i=1 is stored on the rising clock edge and read back combinationally afterwards.
- R4: Addresses A0h–BFh are general-purpose RAM separate from 20h–3Fh.
- R5: Addresses F0h–FFh alias 70h–7Fh. A write through either address reads back at both.
- R6: All other addresses (C0h–EFh) read 00h, and writes to them change no stored byte.
- R7: Offset 00h makes the access indirect. The full address is then pointer_i and the status bank bit is ignored.
- R8: An indirect access whose pointer has low 7 bits equal to 0 (00h or 80h) reads 00h. It selects no port, and a write to it changes nothing.
- R9: After reset every general-purpose byte reads 00h, and sfr_we_o is 0 whenever wr_en_i is 0.
- R10: An access with wr_en_i=0 leaves every stored byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_i | input | 8 | Status byte; bit 5 selects the bank |
| pointer_i | input | 8 | Indirect file-select pointer |
| offset_i | input | 7 | Instruction register offset; 00h means indirect |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Combinational read data |
| sfr_sel_o | output | 1 | Access falls in a special-function register slot |
| sfr_addr_o | output | 8 | Full address forwarded to the register port |
| sfr_we_o | output | 1 | Write strobe to the register port |
| sfr_wdata_o | output | 8 | Write data to the register port |
| sfr_rdata_i | input | 8 | Read data returned by the register port |

## Verification
The bench uses the default map: a 32-slot register window, bank-0 RAM at 20h–7Fh, bank-1 RAM at A0h–BFh and the alias window at F0h–FFh onto 70h–7Fh. This gives 128 storage bytes, all of which random traffic can reach. Because the whole 256-address space is small, random direct and indirect accesses with random reserved status bits hit every class. These include both alias edges, the unimplemented hole and the two null pointer values. Directed cases pin the cross-window write and read sequences.

// File: rtl/banked_regfile_pkg.sv
package banked_regfile_pkg;
  localparam int ADDR_W = 8;
  localparam int OFS_W  = 7;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_SFR  = 2'd1,
    RGN_GPR  = 2'd2,
    RGN_NULL = 2'd3
  } region_e;
endpackage

// File: rtl/banked_regfile_rst_sync.sv
module banked_regfile_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/banked_regfile_addr.sv
module banked_regfile_addr
  import banked_regfile_pkg::*;
#(
  parameter int BANK_BIT = 5
) (
  input  logic [7:0]        status_i,
  input  logic [ADDR_W-1:0] pointer_i,
  input  logic [OFS_W-1:0]  offset_i,
  output logic              indirect_o,
  output logic [ADDR_W-1:0] full_addr_o
);
  always_comb begin
    indirect_o = (offset_i == '0);
    if (indirect_o) full_addr_o = pointer_i;
    else            full_addr_o = {status_i[BANK_BIT], offset_i};
  end
endmodule

// File: rtl/banked_regfile_decode.sv
module banked_regfile_decode
  import banked_regfile_pkg::*;
#(
  parameter logic [OFS_W-1:0]  SFR_SPAN = 7'd32,
  parameter logic [ADDR_W-1:0] B0_LO    = 8'h20,
  parameter logic [ADDR_W-1:0] B0_HI    = 8'h7F,
  parameter logic [ADDR_W-1:0] B1_LO    = 8'hA0,
  parameter logic [ADDR_W-1:0] B1_HI    = 8'hBF,
  parameter logic [ADDR_W-1:0] MIR_LO   = 8'hF0,
  parameter logic [ADDR_W-1:0] MIR_HI   = 8'hFF,
  parameter logic [ADDR_W-1:0] MIR_TGT  = 8'h70,
  parameter int                IDX_W    = 7
) (
  input  logic              indirect_i,
  input  logic [ADDR_W-1:0] full_addr_i,
  output region_e           region_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [ADDR_W-1:0] B0_DEPTH = B0_HI - B0_LO + 8'd1;
  localparam logic [ADDR_W-1:0] MIR_BASE = MIR_TGT - B0_LO;

  logic [ADDR_W-1:0] ofs_b0;
  logic [ADDR_W-1:0] ofs_b1;
  logic [ADDR_W-1:0] ofs_mir;

  always_comb begin
    ofs_b0  = full_addr_i - B0_LO;
    ofs_b1  = B0_DEPTH + (full_addr_i - B1_LO);
    ofs_mir = MIR_BASE + (full_addr_i - MIR_LO);
    region_o = RGN_NONE;
    idx_o    = '0;
    if (indirect_i && (full_addr_i[OFS_W-1:0] == '0)) begin
      region_o = RGN_NULL;
    end else if (full_addr_i[OFS_W-1:0] < SFR_SPAN) begin
      region_o = RGN_SFR;
    end else if (full_addr_i >= B0_LO && full_addr_i <= B0_HI) begin
      region_o = RGN_GPR;
      idx_o    = IDX_W'(ofs_b0);
    end else if (full_addr_i >= B1_LO && full_addr_i <= B1_HI) begin
      region_o = RGN_GPR;
      idx_o    = IDX_W'(ofs_b1);
    end else if (full_addr_i >= MIR_LO && full_addr_i <= MIR_HI) begin
      region_o = RGN_GPR;
      idx_o    = IDX_W'(ofs_mir);
    end
  end
endmodule

// File: rtl/banked_regfile_ram.sv
module banked_regfile_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic              cell_en;
    logic [DATA_W-1:0] cell_d;
    always_comb begin
      cell_en = we_i && (idx_i == IDX_W'(g));
      cell_d  = wdata_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_q[g] <= '0;
      else if (cell_en) mem_q[g] <= cell_d;
    end
  end

  always_comb begin
    if (int'(idx_i) < DEPTH) rdata_o = mem_q[idx_i];
    else                     rdata_o = '0;
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_regfile_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                BANK_BIT = 5,
  parameter logic [OFS_W-1:0]  SFR_SPAN = 7'd32,
  parameter logic [ADDR_W-1:0] B0_LO    = 8'h20,
  parameter logic [ADDR_W-1:0] B0_HI    = 8'h7F,
  parameter logic [ADDR_W-1:0] B1_LO    = 8'hA0,
  parameter logic [ADDR_W-1:0] B1_HI    = 8'hBF,
  parameter logic [ADDR_W-1:0] MIR_LO   = 8'hF0,
  parameter logic [ADDR_W-1:0] MIR_HI   = 8'hFF,
  parameter logic [ADDR_W-1:0] MIR_TGT  = 8'h70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        status_i,
  input  logic [ADDR_W-1:0] pointer_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              sfr_sel_o,
  output logic [ADDR_W-1:0] sfr_addr_o,
  output logic              sfr_we_o,
  output logic [DATA_W-1:0] sfr_wdata_o,
  input  logic [DATA_W-1:0] sfr_rdata_i
);
  localparam int DEPTH = (int'(B0_HI) - int'(B0_LO) + 1) + (int'(B1_HI) - int'(B1_LO) + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic              rst_q;
  logic              indirect;
  logic [ADDR_W-1:0] full_addr;
  region_e           region;
  logic [IDX_W-1:0]  ram_idx;
  logic              ram_we;
  logic [DATA_W-1:0] ram_rdata;

  banked_regfile_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_q)
  );

  banked_regfile_addr #(.BANK_BIT(BANK_BIT)) u_addr (
    .status_i(status_i), .pointer_i(pointer_i), .offset_i(offset_i),
    .indirect_o(indirect), .full_addr_o(full_addr)
  );

  banked_regfile_decode #(
    .SFR_SPAN(SFR_SPAN), .B0_LO(B0_LO), .B0_HI(B0_HI), .B1_LO(B1_LO),
    .B1_HI(B1_HI), .MIR_LO(MIR_LO), .MIR_HI(MIR_HI), .MIR_TGT(MIR_TGT),
    .IDX_W(IDX_W)
  ) u_dec (
    .indirect_i(indirect), .full_addr_i(full_addr),
    .region_o(region), .idx_o(ram_idx)
  );

  always_comb begin
    ram_we = wr_en_i && (region == RGN_GPR);
  end

  banked_regfile_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_ram (
    .clk(clk), .rst_n(rst_q), .we_i(ram_we), .idx_i(ram_idx),
    .wdata_i(wr_data_i), .rdata_o(ram_rdata)
  );

  always_comb begin
    sfr_sel_o   = (region == RGN_SFR);
    sfr_addr_o  = full_addr;
    sfr_we_o    = sfr_sel_o && wr_en_i;
    sfr_wdata_o = wr_data_i;
    unique case (region)
      RGN_SFR: rd_data_o = sfr_rdata_i;
      RGN_GPR: rd_data_o = ram_rdata;
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
  import banked_regfile_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_q,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              sfr_sel_o,
  input logic [ADDR_W-1:0] sfr_addr_o,
  input logic              sfr_we_o,
  input logic [DATA_W-1:0] sfr_rdata_i,
  input region_e           region,
  input logic [ADDR_W-1:0] full_addr,
  input logic              ram_we
);
  // R2
  sfr_read_fwd_chk: assert property (@(posedge clk) disable iff (!rst_q)
    sfr_sel_o |-> (rd_data_o == sfr_rdata_i));
  // R9
  sfr_we_gated_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !wr_en_i |-> !sfr_we_o);
  // R6
  hole_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (region == RGN_NONE) |-> (rd_data_o == '0 && !sfr_sel_o));
  // R8
  null_ptr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (region == RGN_NULL) |-> (rd_data_o == '0 && !sfr_we_o && !ram_we));
  // R3
  write_persist_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(rst_q) && $past(ram_we) && region == RGN_GPR && $stable(full_addr))
      |-> (rd_data_o == $past(wr_data_i)));
  // R2
  sfr_slot_range_chk: assert property (@(posedge clk) disable iff (!rst_q)
    sfr_sel_o |-> (sfr_addr_o[OFS_W-1:0] < 7'd32 && sfr_addr_o[OFS_W-1:0] != '0));
endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_q(rst_q), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o), .sfr_sel_o(sfr_sel_o), .sfr_addr_o(sfr_addr_o),
  .sfr_we_o(sfr_we_o), .sfr_rdata_i(sfr_rdata_i), .region(region),
  .full_addr(full_addr), .ram_we(ram_we)
);

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;
  logic       clk;
  logic       rst_n;
  logic [7:0] status_i, pointer_i, wr_data_i, rd_data_o, sfr_addr_o, sfr_wdata_o, sfr_rdata_i;
  logic [6:0] offset_i;
  logic       wr_en_i, sfr_sel_o, sfr_we_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model [256];

  banked_regfile u_banked_regfile (
    .clk(clk), .rst_n(rst_n), .status_i(status_i), .pointer_i(pointer_i),
    .offset_i(offset_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .sfr_sel_o(sfr_sel_o), .sfr_addr_o(sfr_addr_o),
    .sfr_we_o(sfr_we_o), .sfr_wdata_o(sfr_wdata_o), .sfr_rdata_i(sfr_rdata_i)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // class: 0 hole, 1 register port, 2 storage, 3 null pointer
  function automatic int classify(input bit ind, input logic [7:0] a);
    if (ind && a[6:0] == 7'h00) return 3;
    if (a[6:0] < 7'h20) return 1;
    if ((a >= 8'h20 && a <= 8'h7F) || (a >= 8'hA0 && a <= 8'hBF) || a >= 8'hF0) return 2;
    return 0;
  endfunction

  function automatic logic [7:0] home(input logic [7:0] a);
    if (a >= 8'hF0) return a - 8'h80;
    return a;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic access(input string req, input logic [7:0] st, input logic [7:0] ptr,
                        input logic [6:0] ofs, input bit we, input logic [7:0] d);
    logic [7:0] fa;
    bit ind;
    int cls;
    @(negedge clk);
    status_i = st; pointer_i = ptr; offset_i = ofs; wr_en_i = we; wr_data_i = d;
    sfr_rdata_i = 8'($urandom());
    #2;
    ind = (ofs == 7'h00);
    fa  = ind ? ptr : {st[5], ofs};
    cls = classify(ind, fa);
    case (cls)
      1: check(req, rd_data_o, sfr_rdata_i);
      2: check(req, rd_data_o, model[home(fa)]);
      default: check(req, rd_data_o, 8'h00);
    endcase
    check(req, {7'd0, sfr_sel_o}, {7'd0, cls == 1});
    check(req, {7'd0, sfr_we_o}, {7'd0, cls == 1 && we});
    if (cls == 1) begin
      check(req, sfr_addr_o, fa);
      if (we) check(req, sfr_wdata_o, d);
    end
    if (cls == 2 && we) model[home(fa)] = d;
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    foreach (model[i]) model[i] = 8'h00;
    rst_n = 0; status_i = 0; pointer_i = 0; offset_i = 7'h20;
    wr_en_i = 0; wr_data_i = 0; sfr_rdata_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R9 reset contents
    access("R9", 8'h00, 8'h00, 7'h20, 0, 0);
    access("R9", 8'h00, 8'h00, 7'h7F, 0, 0);
    access("R9", 8'h20, 8'h00, 7'h20, 0, 0);
    access("R9", 8'h20, 8'h00, 7'h3F, 0, 0);
    // R3 bank-0 write and read
    access("R3", 8'h00, 8'h00, 7'h40, 1, 8'h5A);
    access("R3", 8'h00, 8'h00, 7'h40, 0, 0);
    // R1 reserved status bits do not move the bank
    access("R1", 8'hDF, 8'h00, 7'h40, 0, 0);
    access("R1", 8'hC0, 8'h00, 7'h40, 1, 8'h33);
    access("R1", 8'h00, 8'h00, 7'h40, 0, 0);
    // R4 bank-1 window is separate
    access("R4", 8'h20, 8'h00, 7'h25, 1, 8'hA5);
    access("R4", 8'h00, 8'h00, 7'h25, 0, 0);
    access("R4", 8'h20, 8'h00, 7'h25, 0, 0);
    // R5 alias both ways
    access("R5", 8'h00, 8'h00, 7'h75, 1, 8'h11);
    access("R5", 8'h20, 8'h00, 7'h75, 0, 0);
    access("R5", 8'h20, 8'h00, 7'h7A, 1, 8'h22);
    access("R5", 8'h00, 8'h00, 7'h7A, 0, 0);
    access("R5", 8'h00, 8'hF0, 7'h00, 1, 8'h44);
    access("R5", 8'h00, 8'h70, 7'h00, 0, 0);
    // R6 hole
    access("R6", 8'h20, 8'h00, 7'h43, 1, 8'hEE);
    access("R6", 8'h20, 8'h00, 7'h43, 0, 0);
    access("R6", 8'h00, 8'h00, 7'h43, 0, 0);
    access("R6", 8'h00, 8'hEF, 7'h00, 0, 0);
    // R7 indirect ignores bank bit
    access("R7", 8'h20, 8'h40, 7'h00, 0, 0);
    access("R7", 8'h00, 8'hB0, 7'h00, 1, 8'h77);
    access("R7", 8'h20, 8'h00, 7'h30, 0, 0);
    // R8 null pointer
    access("R8", 8'h00, 8'h00, 7'h00, 1, 8'h99);
    access("R8", 8'h20, 8'h80, 7'h00, 1, 8'h98);
    // R2 register port
    access("R2", 8'h00, 8'h00, 7'h05, 1, 8'hC3);
    access("R2", 8'h20, 8'h00, 7'h1F, 0, 0);
    access("R2", 8'h00, 8'h83, 7'h00, 1, 8'h3C);
    // R10 no write without strobe
    access("R10", 8'h00, 8'h00, 7'h40, 0, 8'hFF);
    access("R10", 8'h00, 8'h00, 7'h40, 0, 0);
    // random mix covering R1..R10
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] st, ptr;
      logic [6:0] ofs;
      st  = 8'($urandom());
      ptr = 8'($urandom());
      ofs = ($urandom_range(0, 3) == 0) ? 7'h00 : 7'($urandom());
      access("R3", st, ptr, ofs, $urandom_range(0, 1) == 1, 8'($urandom()));
    end
    // sweep every address indirectly against the model
    for (int a = 0; a < 256; a++) access("R5", 8'h00, 8'(a), 7'h00, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule